// File: doc/BRIEF.md
# Zero-Slack Stable Matching Scheduler

This block computes one crossbar configuration for an N by N combined input and output queued switch. Each time slot has two scheduling phases, one before the departure phase and one after it, so the block is started twice per slot. For every (input, output) pair the caller presents at most one candidate cell. Each candidate carries a valid bit, a slackness value, its rank in the input port's priority list and its rank in the output port's priority list. A smaller rank means the cell is further ahead.

When started, the block keeps only valid cells whose slackness is zero. These are the active cells, and they are latched with their ranks. On each clock cycle the block finds the active cells that have no active cell ahead of them in either list. These are the sinks. It grants one sink and removes every active cell that shares that sink's input or output. It stops when no sink remains or after N grants. When the ranks leave the active cells without ordering cycles, the result is a stable matching. The grant matrix is held until the next start.

Each grant is also reported as it happens, as an (input, output) index pair. The order of the peeling can therefore be observed.

Top module: `jit_match_sched`

## Requirements
- R1: During reset, busy, done and pick_vld are low, and the grant matrix is all zero.
- R2: A start while idle latches the cell set. Only cells that are valid and have slackness exactly zero take part. The final grant matrix contains only such cells. Grant bit i*N+j means that input i is connected to output j.
- R3: At most one cell is granted per iteration. A granted cell has no still-active cell with a smaller input rank in its row, and no still-active cell with a smaller output rank in its column. A cycle with no grant reports pick_vld low.
- R4: When several sinks exist, the one with the lowest input index is granted, then the one with the lowest output index. Each grant appears on pick_in and pick_out with pick_vld high, in the same cycle that its grant bit appears.
- R5: After a grant, all cells in the granted input's row and the granted output's column leave consideration. No input and no output ends with more than one grant.
- R6: done is a single-cycle pulse, and busy falls in the same cycle. With k grants and k < N, done appears k+1 cycles after the start edge. With N grants, it appears N cycles after the start edge.
- R7: When the active cells' orders contain no cycle, every active cell is granted, or is behind a granted cell in its row (input rank) or in its column (output rank).
- R8: When every active cell is blocked by another active cell, no grant is made and done follows one cycle after the start edge.
- R9: A start pulse while busy is ignored. So is any change to the cell inputs while busy. The run completes on the latched set.
- R10: While idle and without a start, the grant matrix stays unchanged even if the cell inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one scheduling phase (sampled while idle) |
| cell_valid | input | N*N | Candidate present at (input i, output j), bit i*N+j |
| cell_slack | input | N*N*SLACK_W | Slackness of each candidate |
| in_rank | input | N*N*RANK_W | Position of each candidate in its input list |
| out_rank | input | N*N*RANK_W | Position of each candidate in its output list |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse at the end of a phase |
| pick_vld | output | 1 | A grant was made in the last iteration |
| pick_in | output | IDX_W | Input index of the last grant |
| pick_out | output | IDX_W | Output index of the last grant |
| grant | output | N*N | Matching, bit i*N+j connects input i to output j |

## Verification
The bench builds the block with N=4, RANK_W=4 and SLACK_W=3. With these values all sixteen cells can have distinct ranks drawn from one permutation, and a full four-grant run stays short enough to repeat many times. Random cases alternate between rank sets taken from a single shared order, which have no cycles and so allow the stability check, and independent row and column orders, which can contain cycles that stop the peeling early. Directed cases cover an empty set, a full diagonal, a two-by-two blocking cycle, nonzero slack everywhere, and two independent sinks whose grant order exposes the input-index tie-break.

// File: rtl/jit_sched_pkg.sv
package jit_sched_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;
endpackage

// File: rtl/jit_sink_detect.sv
module jit_sink_detect #(
   parameter int N      = 4,
   parameter int RANK_W = 4
) (
   input  logic [N*N-1:0]        act,
   input  logic [N*N*RANK_W-1:0] ir,
   input  logic [N*N*RANK_W-1:0] orr,
   output logic [N*N-1:0]        sink
);
   for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         localparam int C = i*N + j;
         logic [N-1:0] blk_row;
         logic [N-1:0] blk_col;
         for (genvar k = 0; k < N; k++) begin : g_cmp
            assign blk_row[k] = act[i*N+k] &&
                  (ir[(i*N+k)*RANK_W +: RANK_W] < ir[C*RANK_W +: RANK_W]);
            assign blk_col[k] = act[k*N+j] &&
                  (orr[(k*N+j)*RANK_W +: RANK_W] < orr[C*RANK_W +: RANK_W]);
         end
         assign sink[C] = act[C] && !(|blk_row) && !(|blk_col);
      end
   end
endmodule

// File: rtl/jit_lowest_pick.sv
module jit_lowest_pick #(
   parameter int W         = 16,
   parameter int PICK_IMPL = 0
) (
   input  logic [W-1:0] req,
   output logic [W-1:0] gnt,
   output logic         any
);
   assign any = |req;
   if (PICK_IMPL == 0) begin : g_arith
      assign gnt = req & (~req + 1'b1);
   end else begin : g_chain
      logic [W:0] seen;
      assign seen[0] = 1'b0;
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign gnt[b]    = req[b] & ~seen[b];
         assign seen[b+1] = seen[b] | req[b];
      end
   end
endmodule

// File: rtl/jit_match_sched.sv
module jit_match_sched
   import jit_sched_pkg::*;
#(
   parameter int N         = 4,
   parameter int RANK_W    = 4,
   parameter int SLACK_W   = 4,
   parameter int PICK_IMPL = 0,
   localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [N*N-1:0]        cell_valid,
   input  logic [N*N*SLACK_W-1:0] cell_slack,
   input  logic [N*N*RANK_W-1:0] in_rank,
   input  logic [N*N*RANK_W-1:0] out_rank,
   output logic                  busy,
   output logic                  done,
   output logic                  pick_vld,
   output logic [IDX_W-1:0]      pick_in,
   output logic [IDX_W-1:0]      pick_out,
   output logic [N*N-1:0]        grant
);
   localparam int CELLS = N*N;
   localparam int ITW   = $clog2(N+1);

   if (N < 2) begin : g_bad_n
      $error("jit_match_sched: N must be at least 2");
   end
   if (RANK_W < IDX_W) begin : g_bad_rank
      $error("jit_match_sched: RANK_W too narrow for N");
   end
   if (PICK_IMPL != 0 && PICK_IMPL != 1) begin : g_bad_pick
      $error("jit_match_sched: PICK_IMPL must be 0 or 1");
   end

   run_state_e                st_q;
   logic [CELLS-1:0]          act_q;
   logic [CELLS*RANK_W-1:0]   ir_q, or_q;
   logic [ITW-1:0]            iter_q;
   logic [CELLS-1:0]          zs, sink, pick, kill;
   logic                      any;
   logic [IDX_W-1:0]          enc_i, enc_o;

   assign busy = (st_q == ST_RUN);

   for (genvar c = 0; c < CELLS; c++) begin : g_zs
      assign zs[c] = cell_valid[c] && (cell_slack[c*SLACK_W +: SLACK_W] == '0);
   end

   jit_sink_detect #(.N(N), .RANK_W(RANK_W)) u_sink (
      .act (act_q),
      .ir  (ir_q),
      .orr (or_q),
      .sink(sink)
   );

   jit_lowest_pick #(.W(CELLS), .PICK_IMPL(PICK_IMPL)) u_pick (
      .req(sink),
      .gnt(pick),
      .any(any)
   );

   always_comb begin
      enc_i = '0;
      enc_o = '0;
      for (int c = 0; c < CELLS; c++) begin
         if (pick[c]) begin
            enc_i = IDX_W'(c / N);
            enc_o = IDX_W'(c % N);
         end
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_kr
      for (genvar j = 0; j < N; j++) begin : g_kc
         assign kill[i*N+j] = (enc_i == IDX_W'(i)) || (enc_o == IDX_W'(j));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         act_q    <= '0;
         ir_q     <= '0;
         or_q     <= '0;
         iter_q   <= '0;
         grant    <= '0;
         done     <= 1'b0;
         pick_vld <= 1'b0;
         pick_in  <= '0;
         pick_out <= '0;
      end else begin
         done     <= 1'b0;
         pick_vld <= 1'b0;
         if (st_q == ST_IDLE) begin
            if (start) begin
               st_q   <= ST_RUN;
               act_q  <= zs;
               ir_q   <= in_rank;
               or_q   <= out_rank;
               iter_q <= '0;
               grant  <= '0;
            end
         end else begin
            if (any) begin
               grant    <= grant | pick;
               act_q    <= act_q & ~kill;
               iter_q   <= iter_q + 1'b1;
               pick_vld <= 1'b1;
               pick_in  <= enc_i;
               pick_out <= enc_o;
            end
            if (!any || iter_q == ITW'(N-1)) begin
               st_q <= ST_IDLE;
               done <= 1'b1;
            end
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R6
   AST_ITER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (iter_q < ITW'(N))); // R6
   AST_PICK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $onehot0(pick)); // R3
   AST_PICK_SINK: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((pick & ~sink) == '0)); // R3
   AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(grant)); // R10
   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> (busy || done)); // R9

   for (genvar i = 0; i < N; i++) begin : g_chk
      logic [N-1:0] colv;
      for (genvar k = 0; k < N; k++) begin : g_cv
         assign colv[k] = grant[k*N+i];
      end
      AST_ROW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(grant[i*N +: N])); // R5
      AST_COL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(colv)); // R5
   end
endmodule

// File: tb/jit_match_sched_tb.sv
module jit_match_sched_tb;
   localparam int N  = 4;
   localparam int RW = 4;
   localparam int SW = 3;
   localparam int IW = 2;
   localparam int CELLS = N*N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [CELLS-1:0]    cell_valid = '0;
   logic [CELLS*SW-1:0] cell_slack = '0;
   logic [CELLS*RW-1:0] in_rank = '0;
   logic [CELLS*RW-1:0] out_rank = '0;
   logic busy, done, pick_vld;
   logic [IW-1:0] pick_in, pick_out;
   logic [CELLS-1:0] grant;

   always #5 clk = ~clk;

   jit_match_sched #(.N(N), .RANK_W(RW), .SLACK_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cell_valid(cell_valid), .cell_slack(cell_slack),
      .in_rank(in_rank), .out_rank(out_rank),
      .busy(busy), .done(done), .pick_vld(pick_vld),
      .pick_in(pick_in), .pick_out(pick_out), .grant(grant)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int a_v [N][N];
   int a_s [N][N];
   int a_ir [N][N];
   int a_or [N][N];
   int act0 [N][N];
   int exp_i [N];
   int exp_o [N];
   int exp_k;
   bit exp_stuck;
   logic [CELLS-1:0] exp_gv;
   int last_n;
   int perm_a [CELLS];
   int perm_b [CELLS];

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int actv, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, actv, expv);
      end
   endtask

   task automatic shuffle(output int p [CELLS]);
      for (int c = 0; c < CELLS; c++) p[c] = c;
      for (int c = CELLS-1; c > 0; c--) begin
         int r;
         int t;
         r = $urandom_range(0, c);
         t = p[c]; p[c] = p[r]; p[r] = t;
      end
   endtask

   task automatic drive_inputs();
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            int c;
            c = i*N + j;
            cell_valid[c]         = (a_v[i][j] != 0);
            cell_slack[c*SW +: SW] = SW'(a_s[i][j]);
            in_rank[c*RW +: RW]    = RW'(a_ir[i][j]);
            out_rank[c*RW +: RW]   = RW'(a_or[i][j]);
         end
      end
   endtask

   function automatic bit is_sink(input int a [N][N], input int i, input int j);
      if (a[i][j] == 0) return 1'b0;
      for (int k = 0; k < N; k++) begin
         if (a[i][k] != 0 && a_ir[i][k] < a_ir[i][j]) return 1'b0;
         if (a[k][j] != 0 && a_or[k][j] < a_or[i][j]) return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic ref_model();
      int a [N][N];
      int left;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            act0[i][j] = (a_v[i][j] != 0 && a_s[i][j] == 0) ? 1 : 0;
            a[i][j] = act0[i][j];
         end
      exp_k = 0;
      exp_gv = '0;
      for (int it = 0; it < N; it++) begin
         int pi;
         int pj;
         bit found;
         found = 1'b0; pi = 0; pj = 0;
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
               if (!found && is_sink(a, i, j)) begin
                  found = 1'b1; pi = i; pj = j;
               end
         if (!found) break;
         exp_i[exp_k] = pi;
         exp_o[exp_k] = pj;
         exp_k++;
         exp_gv[pi*N+pj] = 1'b1;
         for (int k = 0; k < N; k++) begin
            a[pi][k] = 0;
            a[k][pj] = 0;
         end
      end
      left = 0;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) left += a[i][j];
      exp_stuck = (left != 0);
   endtask

   task automatic check_result(input string tag);
      for (int i = 0; i < N; i++) begin
         int rc;
         int cc;
         rc = 0; cc = 0;
         for (int k = 0; k < N; k++) begin
            rc += int'(grant[i*N+k]);
            cc += int'(grant[k*N+i]);
         end
         chk(rc <= 1 && cc <= 1, "R5", {tag, " grants per port"}, rc + 10*cc, 0);
      end
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++)
            if (grant[i*N+j] && act0[i][j] == 0)
               chk(1'b0, "R2", {tag, " grant on inactive cell"}, i*N+j, -1);
      if (!exp_stuck) begin
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
               if (act0[i][j] != 0) begin
                  bit ok;
                  ok = grant[i*N+j];
                  for (int k = 0; k < N; k++) begin
                     if (act0[i][k] != 0 && a_ir[i][k] < a_ir[i][j] && grant[i*N+k]) ok = 1'b1;
                     if (act0[k][j] != 0 && a_or[k][j] < a_or[i][j] && grant[k*N+j]) ok = 1'b1;
                  end
                  chk(ok, "R7", {tag, " unstable cell"}, i*N+j, 1);
               end
      end
   endtask

   task automatic run_case(input string tag, input bit poke);
      int n;
      drive_inputs();
      ref_model();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done) begin
         if (poke && n == 1) begin
            start = 1'b1;
            cell_valid = '0;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         n++;
         if (n <= exp_k) begin
            chk(pick_vld == 1'b1, "R3", {tag, " pick_vld"}, int'(pick_vld), 1);
            chk(pick_in == IW'(exp_i[n-1]) && pick_out == IW'(exp_o[n-1]), "R4",
                {tag, " pick order"}, int'(pick_in)*N + int'(pick_out),
                exp_i[n-1]*N + exp_o[n-1]);
         end else begin
            chk(pick_vld == 1'b0, "R3", {tag, " no pick"}, int'(pick_vld), 0);
         end
         if (n > 3*N) begin
            chk(1'b0, "R6", {tag, " done never seen"}, n, 3*N);
            break;
         end
      end
      start = 1'b0;
      last_n = n;
      chk(n == ((exp_k < N) ? exp_k + 1 : N), "R6", {tag, " done latency"}, n,
          (exp_k < N) ? exp_k + 1 : N);
      chk(busy == 1'b0, "R6", {tag, " busy with done"}, int'(busy), 0);
      chk(grant == exp_gv, "R2", {tag, " grant matrix"}, int'(grant), int'(exp_gv));
      check_result(tag);
      @(negedge clk);
      chk(done == 1'b0, "R6", {tag, " done one cycle"}, int'(done), 0);
   endtask

   task automatic clear_cells();
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            a_v[i][j] = 0; a_s[i][j] = 0;
            a_ir[i][j] = j; a_or[i][j] = i;
         end
   endtask

   task automatic random_cells(input bit acyclic);
      shuffle(perm_a);
      shuffle(perm_b);
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            a_v[i][j]  = ($urandom_range(0, 99) < 70) ? 1 : 0;
            a_s[i][j]  = ($urandom_range(0, 9) < 6) ? 0 : int'($urandom_range(1, 7));
            a_ir[i][j] = perm_a[i*N+j];
            a_or[i][j] = acyclic ? perm_a[i*N+j] : perm_b[i*N+j];
         end
   endtask

   initial begin
      logic [CELLS-1:0] held;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && pick_vld == 0 && grant == '0, "R1",
          "reset outputs", int'(grant), 0);
      rst_n = 1'b1;
      @(negedge clk);

      clear_cells();
      run_case("empty", 1'b0);
      chk(grant == '0, "R2", "empty set no grant", int'(grant), 0);

      clear_cells();
      for (int i = 0; i < N; i++) a_v[i][i] = 1;
      run_case("diagonal", 1'b0);

      clear_cells();
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin a_v[i][j] = 1; a_s[i][j] = 1 + (i+j) % 7; end
      run_case("slack", 1'b0);
      chk(grant == '0, "R2", "nonzero slack ignored", int'(grant), 0);

      clear_cells();
      a_v[0][0] = 1; a_v[0][1] = 1; a_v[1][0] = 1; a_v[1][1] = 1;
      a_ir[0][0] = 0; a_ir[0][1] = 1; a_ir[1][1] = 0; a_ir[1][0] = 1;
      a_or[1][0] = 0; a_or[0][0] = 1; a_or[0][1] = 0; a_or[1][1] = 1;
      run_case("cycle", 1'b0);
      chk(grant == '0, "R8", "cycle no grant", int'(grant), 0);
      chk(last_n == 1, "R8", "cycle done latency", last_n, 1);

      clear_cells();
      a_v[1][0] = 1; a_v[0][1] = 1; a_v[2][3] = 1;
      run_case("tiebreak", 1'b0);
      chk(exp_k == 3 && exp_i[0] == 0 && exp_i[1] == 1, "R4", "lowest input first",
          exp_i[0], 0);

      clear_cells();
      for (int i = 0; i < N; i++) a_v[i][N-1-i] = 1;
      run_case("poke", 1'b1);
      chk(grant == 16'h1248, "R9", "start while busy ignored", int'(grant), 16'h1248);

      held = grant;
      random_cells(1'b1);
      drive_inputs();
      repeat (3) @(negedge clk);
      chk(grant == held, "R10", "grant held while idle", int'(grant), int'(held));

      for (int t = 0; t < 60; t++) begin
         random_cells(t[0] == 1'b0);
         run_case(t[0] ? "rand_free" : "rand_acyclic", 1'b0);
         if (t[0] == 1'b0)
            chk(!exp_stuck, "R7", "acyclic set fully peeled", int'(exp_stuck), 0);
      end
      summary();
   end
endmodule